// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two 64-bit operands and a carry-in in pure combinational logic. It returns a 64-bit sum and a carry-out. The word is cut into eleven slices that widen toward the most significant end. The lowest slice is a plain ripple chain fed by the external carry-in.

Every higher slice ripples its own bits with the carry-in held at zero. It then forms the carry-in-of-one answer by incrementing that provisional result, so no second ripple chain is needed. The true carry arriving from the slice below either selects between the two answers or gates the increment.

A parameter picks one of two increment styles:
- a plus-one converter followed by a row of 2:1 selectors;
- a chain of half adders seeded by the incoming slice carry.

The slice carries form a short select chain across the word. This chain is what makes the adder faster than a single 64-bit ripple.

Top module: `sqrt_csel_add`

## Requirements
- R1: Slice widths from bit 0 upward are 2, 2, 3, 4, 5, 6, 7, 8, 8, 9 and 10, so slice g starts at bit 0, 2, 4, 7, 11, 16, 22, 29, 37, 45 or 54. A carry produced just below any slice start lands in that slice: a = (1<<start)-1 with b = 1 gives sum = 1<<start.
- R2: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i, in both increment styles (INC_BEC = 0, INC_HALF = 1).
- R3: The external carry-in enters the lowest slice's ripple chain: a_i = b_i = 0 with cin_i = 1 gives sum_o = 1 and cout_o = 0.
- R4: In the converter style, a slice of n bits treats {provisional carry, provisional sum} as an (n+1)-bit word and adds one. An all-ones word wraps to zero, so a slice of all ones that receives a carry becomes zero and passes a carry upward.
- R5: A slice whose incoming carry is 0 delivers its provisional (carry-in-zero) sum and carry unchanged. With a_i & b_i == 0 and cin_i = 0, the sum is a_i | b_i.
- R6: In the half-adder style, the carry leaving a slice is the OR of its provisional carry and the last half-adder carry, and these two are never both 1. Adding all ones to all ones with cin_i = 1 gives all ones and carry-out 1.
- R7: With a_i = 0x76 and b_i = 0x5A (low bits 1110110 and 1011010) and cin_i = 0, sum bits 1:0 and 3:2 are both 00, and the low byte of the sum is 0xD0.
- R8: A carry generated at bit 0 travels through every slice: all ones plus one gives sum_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum bits |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
In each slice, the provisional ripple carry and the incremented carry from the slice below are both live at once. The hard case is a slice that overflows by itself while also receiving a carry. Operands whose slices are all ones, added with carry-in set, provoke this. Single-bit increments placed just below each slice start drive a carry into a slice whose provisional sum is all ones, so the incremented path is exercised there. Both style instances are judged against a 65-bit reference sum computed in the bench, and exact expected words are also checked for the boundary and worked-example cases.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

    localparam int NGRP = 11;

    // Slice widths, least significant slice first.
    localparam int GRP_W [NGRP] = '{2, 2, 3, 4, 5, 6, 7, 8, 8, 9, 10};

    // Start bit of slice g (sum of the widths below it).
    function automatic int grp_lo(input int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++) acc += GRP_W[i];
        return acc;
    endfunction

    localparam int DW = grp_lo(NGRP);

    typedef enum logic {
        INC_BEC  = 1'b0,
        INC_HALF = 1'b1
    } inc_style_e;

endpackage

// File: rtl/sqcs_ripple.sv
module sqcs_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);

    logic [W:0] c_d;

    assign c_d[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s_o[i]    = a_i[i] ^ b_i[i] ^ c_d[i];
        assign c_d[i+1]  = (a_i[i] & b_i[i]) | (b_i[i] & c_d[i]) | (c_d[i] & a_i[i]);
    end

    assign co_o = c_d[W];

    always_comb begin
        assert_ripple_sum_R2: assert ({co_o, s_o} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("ripple chain result differs from operand sum");
    end

endmodule

// File: rtl/sqcs_inc.sv
module sqcs_inc #(
    parameter int W = 4
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    // run_d[i] is 1 when every input bit below i is 1, so bit i toggles.
    logic [W-1:0] run_d;

    assign run_d[0] = 1'b1;
    for (genvar i = 1; i < W; i++) begin : g_run
        assign run_d[i] = run_d[i-1] & in_i[i-1];
    end

    assign out_o = in_i ^ run_d;

    always_comb begin
        assert_inc_plus_one_R4: assert (out_o == W'(in_i + W'(1)))
        else $error("plus-one converter output wrong");
    end

endmodule

// File: rtl/sqcs_group.sv
module sqcs_group
    import sqcs_pkg::*;
#(
    parameter int         W     = 4,
    parameter inc_style_e STYLE = INC_BEC
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);

    typedef struct packed {
        logic         co;
        logic [W-1:0] s;
    } res_t;

    logic [W-1:0] ps_d;
    logic         pc_d;
    res_t         res_d;

    sqcs_ripple #(.W(W)) u_rca0 (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .s_o   (ps_d),
        .co_o  (pc_d)
    );

    if (STYLE == INC_BEC) begin : g_bec
        logic [W:0] x_d;

        sqcs_inc #(.W(W+1)) u_inc (
            .in_i  ({pc_d, ps_d}),
            .out_o (x_d)
        );

        always_comb begin
            if (cin_i) res_d = res_t'(x_d);
            else       res_d = res_t'({pc_d, ps_d});
        end
    end else begin : g_half
        logic [W:0]   hc_d;
        logic [W-1:0] hs_d;

        assign hc_d[0] = cin_i;
        for (genvar i = 0; i < W; i++) begin : g_ha
            assign hs_d[i]   = ps_d[i] ^ hc_d[i];
            assign hc_d[i+1] = ps_d[i] & hc_d[i];
        end

        always_comb begin
            res_d.s  = hs_d;
            res_d.co = pc_d | hc_d[W];
        end

        always_comb begin
            assert_half_carry_excl_R6: assert (!(pc_d && hc_d[W]))
            else $error("provisional and half-adder carries both set");
        end
    end

    assign s_o  = res_d.s;
    assign co_o = res_d.co;

    always_comb begin
        assert_zero_carry_pass_R5: assert (cin_i || ({co_o, s_o} == {pc_d, ps_d}))
        else $error("slice altered its carry-0 result without a carry");
        assert_group_sum_R2: assert ({co_o, s_o} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("slice result differs from operand sum");
    end

endmodule

// File: rtl/sqrt_csel_add.sv
module sqrt_csel_add
    import sqcs_pkg::*;
#(
    parameter inc_style_e STYLE = INC_BEC
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o
);

    // gc_d[g] is the carry entering slice g.
    logic [NGRP:0] gc_d;

    assign gc_d[0] = cin_i;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        localparam int LO = grp_lo(g);
        localparam int W  = GRP_W[g];

        if (g == 0) begin : g_base
            sqcs_ripple #(.W(W)) u_rca (
                .a_i   (a_i[LO +: W]),
                .b_i   (b_i[LO +: W]),
                .cin_i (gc_d[g]),
                .s_o   (sum_o[LO +: W]),
                .co_o  (gc_d[g+1])
            );
        end else begin : g_sel
            sqcs_group #(.W(W), .STYLE(STYLE)) u_grp (
                .a_i   (a_i[LO +: W]),
                .b_i   (b_i[LO +: W]),
                .cin_i (gc_d[g]),
                .s_o   (sum_o[LO +: W]),
                .co_o  (gc_d[g+1])
            );
        end
    end

    assign cout_o = gc_d[NGRP];

    always_comb begin
        assert_word_sum_R2: assert ({cout_o, sum_o} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i}))
        else $error("word sum differs from operand sum");
    end

endmodule

// File: tb/test_sqrt_csel_add.sv
module test_sqrt_csel_add;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a, b;
    logic        cin;
    logic [63:0] sum_bec, sum_ha;
    logic        cout_bec, cout_ha;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sqrt_csel_add #(.STYLE(sqcs_pkg::INC_BEC)) i_sqrt_csel_add (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_bec), .cout_o(cout_bec)
    );

    sqrt_csel_add #(.STYLE(sqcs_pkg::INC_HALF)) i_sqrt_csel_add_ha (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_ha), .cout_o(cout_ha)
    );

    // Stimulus table: {a, b, cin}; expected values come from a 65-bit add.
    localparam logic [128:0] VEC [8] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
        {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},
        {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1},
        {64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1},
        {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
        {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1}
    };

    task automatic chk(input string tag, input logic [64:0] got, input logic [64:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c,
                         input string tag);
        logic [64:0] ref_sum;
        a = x; b = y; cin = c;
        @(negedge clk);
        ref_sum = {1'b0, x} + {1'b0, y} + {64'd0, c};
        chk({tag, " converter"}, {cout_bec, sum_bec}, ref_sum);
        chk({tag, " half-adder"}, {cout_ha, sum_ha}, ref_sum);
    endtask

    initial begin
        int wid [11] = '{2, 2, 3, 4, 5, 6, 7, 8, 8, 9, 10};
        int lo;
        a = '0; b = '0; cin = 1'b0;
        repeat (2) @(negedge clk);
        // Quiet state: zero operands give zero result.
        chk("R2 idle converter", {cout_bec, sum_bec}, 65'd0);
        chk("R2 idle half-adder", {cout_ha, sum_ha}, 65'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            apply(VEC[i][128:65], VEC[i][64:1], VEC[i][0], "R2 table");
        end

        // R3: carry-in alone
        apply(64'd0, 64'd0, 1'b1, "R3 cin only");
        chk("R3 exact", {cout_bec, sum_bec}, 65'd1);

        // R7: worked example
        apply(64'h76, 64'h5A, 1'b0, "R7 example");
        chk("R7 low nibble", {61'd0, sum_bec[3:0]}, 65'd0);
        chk("R7 low byte", {57'd0, sum_ha[7:0]}, 65'hD0);

        // R1: carry landing at each slice start
        lo = 0;
        for (int g = 1; g < 11; g++) begin
            lo += wid[g-1];
            apply((64'd1 << lo) - 64'd1, 64'd1, 1'b0, "R1 boundary");
            chk("R1 exact converter", {cout_bec, sum_bec}, {1'b0, 64'd1 << lo});
            chk("R1 exact half-adder", {cout_ha, sum_ha}, {1'b0, 64'd1 << lo});
        end

        // R8: carry through every slice
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R8 full ripple");
        chk("R8 exact", {cout_ha, sum_ha}, {1'b1, 64'd0});

        // R4: slice of all ones wraps when it receives a carry
        apply(64'h0000_0000_0000_0078, 64'd0, 1'b0, "R4 no carry");
        apply(64'h0000_0000_0000_007F, 64'd1, 1'b0, "R4 wrap");
        chk("R4 exact", {cout_bec, sum_bec}, 65'h80);

        // R5: no carries anywhere
        apply(64'hF0F0_0F0F_3300_00CC, 64'h0F0F_F0F0_00CC_3300, 1'b0, "R5 disjoint");
        chk("R5 exact", {cout_bec, sum_bec}, {1'b0, 64'hFFFF_FFFF_33CC_33CC});

        // R6: slice overflow plus incoming carry
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 double");
        chk("R6 exact", {cout_ha, sum_ha}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});

        // R2: random operands
        for (int k = 0; k < 300; k++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R2 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule